// File: doc/BRIEF.md
# Float-to-Integer Converter

This block turns a value in a wide internal floating-point register format into a 64-bit integer. It produces either a two's-complement signed result or an unsigned result. The input word is a sign bit, a 17-bit biased exponent and a 64-bit significand whose top bit is an explicit integer bit. The caller supplies a rounding mode with each operand. Each result comes with an invalid-operation flag and an inexact flag.

Every conversion that cannot be represented raises the invalid flag, and so does any input whose exponent field is all ones (NaN or infinity). In that case the output carries one fixed indefinite pattern, 0x8000_0000_0000_0000, and this holds for unsigned conversions as well. The datapath is purely combinational and is registered once at the output. A one-bit valid travels alongside the data.

Top module: `fp_to_int_cvt`

## Requirements
- R1: `out_valid` equals the value `in_valid` had at the previous rising clock edge, so the latency is exactly one cycle. Reset (`rst_n` low) forces `out_valid`, `out_int` and both flags to 0.
- R2: An operand whose exponent field is all ones (0x1FFFF) raises `out_invalid` whatever the significand, the sign, the rounding mode or the integer mode.
- R3: Whenever `out_invalid` is 1, `out_int` is 0x8000_0000_0000_0000. This holds with `in_unsigned` = 0 (signed) and with `in_unsigned` = 1 (unsigned).
- R4: In signed mode, a rounded value in the range -2^63 to 2^63-1 is valid and is returned in two's complement. A rounded value outside that range is invalid. Exactly -2^63 is valid.
- R5: In unsigned mode, a negative value that rounds to a nonzero integer is invalid, and so is any rounded value of 2^64 or more. A negative value that rounds to zero yields 0 and is valid.
- R6: `in_rmode` selects the rounding: 00 rounds to nearest with ties to even, 01 rounds toward minus infinity, 10 rounds toward plus infinity, and 11 truncates toward zero. Rounding is applied before the range check, so a value just below a limit can round over it and become invalid.
- R7: `out_inexact` is 1 exactly when nonzero fraction bits were discarded and the result is valid. It is never 1 together with `out_invalid`.
- R8: The operand value is (-1)^sign × sig × 2^(exp − 0xFFFF − 63). A significand whose integer bit is 0 is converted by its value. An all-zero operand gives 0 with no flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operand present this cycle |
| in_sign | input | 1 | Operand sign |
| in_exp | input | 17 | Biased exponent, bias 0xFFFF |
| in_sig | input | 64 | Significand, bit 63 is the integer bit |
| in_unsigned | input | 1 | 1 = unsigned conversion, 0 = signed |
| in_rmode | input | 2 | Rounding mode (00 nearest-even, 01 down, 10 up, 11 toward zero) |
| out_valid | output | 1 | Result present |
| out_int | output | 64 | Integer result |
| out_invalid | output | 1 | Invalid-operation flag |
| out_inexact | output | 1 | Inexact flag |

## Verification
The only state in the block is the output register. A corrupted stage therefore shows up in the first cycle after the offending operand, as a wrong integer, a wrong flag or a missing valid. It is never hidden for longer. The stimulus is chosen so that each internal decision is visible on its own at the ports: the alignment shift, the round increment, the carry out of rounding, and the signed or unsigned range limit. Examples are a tie that rounds to even, a value just under 2^63 that rounds up into overflow, and a left-shifted small significand. A broken rounding rule or range limit then changes a specific expected word or flag in the very next output.

// File: rtl/fpcvt_pkg.sv
package fpcvt_pkg;

    typedef enum logic [1:0] {
        RND_NEAR = 2'b00,
        RND_DOWN = 2'b01,
        RND_UP   = 2'b10,
        RND_ZERO = 2'b11
    } rnd_mode_e;

    // round-up decision from the kept lsb, the first dropped bit and the rest
    function automatic logic round_up(rnd_mode_e mode, logic neg, logic lsb,
                                      logic rbit, logic sbit);
        logic any_lost;
        any_lost = rbit | sbit;
        case (mode)
            RND_NEAR: return rbit & (sbit | lsb);
            RND_DOWN: return any_lost & neg;
            RND_UP:   return any_lost & ~neg;
            default:  return 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/fpcvt_classify.sv
module fpcvt_classify #(
    parameter int EXP_W = 17,
    parameter int SIG_W = 64
) (
    input  logic [EXP_W-1:0] exp_i,
    input  logic [SIG_W-1:0] sig_i,
    output logic             special_o,
    output logic             is_nan_o,
    output logic             is_zero_o
);
    logic exp_max;
    logic frac_nz;

    always_comb begin
        exp_max   = &exp_i;
        frac_nz   = |sig_i[SIG_W-2:0];
        special_o = exp_max;
        is_nan_o  = exp_max & frac_nz;
        is_zero_o = ~(|sig_i);
    end
endmodule

// File: rtl/fpcvt_align.sv
module fpcvt_align #(
    parameter int EXP_W = 17,
    parameter int SIG_W = 64
) (
    input  logic [EXP_W-1:0] exp_i,
    input  logic [SIG_W-1:0] sig_i,
    output logic [SIG_W-1:0] int_o,
    output logic             rbit_o,
    output logic             sbit_o,
    output logic             big_o
);
    localparam int BIAS = (1 << (EXP_W - 1)) - 1;
    localparam int SH_W = $clog2(2 * SIG_W) + 1;

    int                 ue;
    int                 rsh;
    int                 lsh;
    logic [2*SIG_W-1:0] wide;

    always_comb begin
        ue     = int'({{(32-EXP_W){1'b0}}, exp_i}) - BIAS;
        rsh    = (SIG_W - 1) - ue;
        lsh    = ue - (SIG_W - 1);
        wide   = '0;
        int_o  = '0;
        rbit_o = 1'b0;
        sbit_o = 1'b0;
        big_o  = 1'b0;
        if (rsh > SIG_W) begin
            // magnitude below one half: everything is sticky
            sbit_o = |sig_i;
        end else if (rsh >= 0) begin
            wide   = {sig_i, {SIG_W{1'b0}}} >> SH_W'(rsh);
            int_o  = wide[2*SIG_W-1:SIG_W];
            rbit_o = wide[SIG_W-1];
            sbit_o = |wide[SIG_W-2:0];
        end else if (lsh < SIG_W) begin
            wide  = {{SIG_W{1'b0}}, sig_i} << SH_W'(lsh);
            int_o = wide[SIG_W-1:0];
            big_o = |wide[2*SIG_W-1:SIG_W];
        end else begin
            big_o = |sig_i;
        end
    end
endmodule

// File: rtl/fpcvt_round.sv
module fpcvt_round
    import fpcvt_pkg::*;
#(
    parameter int W = 64
) (
    input  logic         sign_i,
    input  logic         uns_i,
    input  rnd_mode_e    mode_i,
    input  logic         special_i,
    input  logic [W-1:0] int_i,
    input  logic         rbit_i,
    input  logic         sbit_i,
    input  logic         big_i,
    output logic [W-1:0] res_o,
    output logic         inv_o,
    output logic         inx_o
);
    localparam logic [W-1:0] INDEF = {1'b1, {(W-1){1'b0}}};

    logic       inc;
    logic [W:0] mag;
    logic       ovf;
    logic       range_bad;
    logic [W-1:0] value;

    always_comb begin
        inc = round_up(mode_i, sign_i, int_i[0], rbit_i, sbit_i);
        mag = {1'b0, int_i} + {{W{1'b0}}, inc};
        ovf = big_i | mag[W];
        if (uns_i) begin
            range_bad = ovf | (sign_i & (|mag[W-1:0]));
            value     = mag[W-1:0];
        end else if (sign_i) begin
            range_bad = ovf | (mag[W-1] & (|mag[W-2:0]));
            value     = ~mag[W-1:0] + 1'b1;
        end else begin
            range_bad = ovf | mag[W-1];
            value     = mag[W-1:0];
        end
        inv_o = special_i | range_bad;
        inx_o = ~inv_o & (rbit_i | sbit_i);
        res_o = inv_o ? INDEF : value;
    end
endmodule

// File: rtl/fp_to_int_cvt.sv
module fp_to_int_cvt
    import fpcvt_pkg::*;
#(
    parameter int EXP_W = 17,
    parameter int SIG_W = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic             in_sign,
    input  logic [EXP_W-1:0] in_exp,
    input  logic [SIG_W-1:0] in_sig,
    input  logic             in_unsigned,
    input  logic [1:0]       in_rmode,
    output logic             out_valid,
    output logic [SIG_W-1:0] out_int,
    output logic             out_invalid,
    output logic             out_inexact
);
    localparam int INT_W = SIG_W;

    typedef struct packed {
        logic             vld;
        logic [INT_W-1:0] res;
        logic             inv;
        logic             inx;
    } stage_t;

    stage_t st_d, st_q;

    logic             special;
    logic             is_nan;
    logic             is_zero;
    logic [INT_W-1:0] al_int;
    logic             al_rbit;
    logic             al_sbit;
    logic             al_big;
    logic [INT_W-1:0] rn_res;
    logic             rn_inv;
    logic             rn_inx;

    fpcvt_classify #(.EXP_W(EXP_W), .SIG_W(SIG_W)) u_class (
        .exp_i     (in_exp),
        .sig_i     (in_sig),
        .special_o (special),
        .is_nan_o  (is_nan),
        .is_zero_o (is_zero)
    );

    fpcvt_align #(.EXP_W(EXP_W), .SIG_W(SIG_W)) u_align (
        .exp_i  (in_exp),
        .sig_i  (in_sig),
        .int_o  (al_int),
        .rbit_o (al_rbit),
        .sbit_o (al_sbit),
        .big_o  (al_big)
    );

    fpcvt_round #(.W(INT_W)) u_round (
        .sign_i    (in_sign),
        .uns_i     (in_unsigned),
        .mode_i    (rnd_mode_e'(in_rmode)),
        .special_i (special | is_nan),
        .int_i     (al_int),
        .rbit_i    (al_rbit),
        .sbit_i    (al_sbit),
        .big_i     (al_big & ~is_zero),
        .res_o     (rn_res),
        .inv_o     (rn_inv),
        .inx_o     (rn_inx)
    );

    always_comb begin
        st_d     = st_q;
        st_d.vld = in_valid;
        if (in_valid) begin
            st_d.res = rn_res;
            st_d.inv = rn_inv;
            st_d.inx = rn_inx;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_valid   = st_q.vld;
    assign out_int     = st_q.res;
    assign out_invalid = st_q.inv;
    assign out_inexact = st_q.inx;
endmodule

// File: rtl/fpcvt_chk.sv
module fpcvt_chk #(
    parameter int EXP_W = 17,
    parameter int SIG_W = 64
) (
    input logic             clk,
    input logic             rst_n,
    input logic             in_valid,
    input logic             in_sign,
    input logic [EXP_W-1:0] in_exp,
    input logic [SIG_W-1:0] in_sig,
    input logic             in_unsigned,
    input logic             out_valid,
    input logic [SIG_W-1:0] out_int,
    input logic             out_invalid,
    input logic             out_inexact
);
    localparam int BIAS = (1 << (EXP_W - 1)) - 1;
    localparam logic [EXP_W-1:0] EXP_2P63 = EXP_W'(BIAS + SIG_W - 1);
    localparam logic [SIG_W-1:0] INDEF = {1'b1, {(SIG_W-1){1'b0}}};

    AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);                                            // R1
    AST_IDLE_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);                                          // R1
    AST_SPECIAL_INVALID: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && (&in_exp)) |=> out_invalid);                           // R2
    AST_INDEF_PATTERN: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_invalid) |-> (out_int == INDEF));                 // R3
    AST_SIGNED_TOO_BIG: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !in_unsigned && !in_sign && in_sig[SIG_W-1]
         && in_exp >= EXP_2P63) |=> out_invalid);                           // R4
    AST_FLAGS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> !(out_invalid && out_inexact));                       // R7
endmodule

bind fp_to_int_cvt fpcvt_chk #(.EXP_W(EXP_W), .SIG_W(SIG_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .in_valid    (in_valid),
    .in_sign     (in_sign),
    .in_exp      (in_exp),
    .in_sig      (in_sig),
    .in_unsigned (in_unsigned),
    .out_valid   (out_valid),
    .out_int     (out_int),
    .out_invalid (out_invalid),
    .out_inexact (out_inexact)
);

// File: tb/fp_to_int_cvt_test.sv
module fp_to_int_cvt_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_sign = 1'b0;
    logic [16:0] in_exp = '0;
    logic [63:0] in_sig = '0;
    logic        in_unsigned = 1'b0;
    logic [1:0]  in_rmode = 2'b00;
    logic        out_valid;
    logic [63:0] out_int;
    logic        out_invalid;
    logic        out_inexact;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    typedef struct {
        logic [63:0] r;
        logic        iv;
        logic        ix;
        string       tag;
    } exp_t;
    exp_t sb[$];

    localparam logic [63:0] IND = 64'h8000_0000_0000_0000;
    localparam logic [63:0] ONE = 64'h8000_0000_0000_0000; // integer bit only

    always #5 clk = ~clk;

    fp_to_int_cvt uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sign(in_sign),
        .in_exp(in_exp), .in_sig(in_sig), .in_unsigned(in_unsigned),
        .in_rmode(in_rmode), .out_valid(out_valid), .out_int(out_int),
        .out_invalid(out_invalid), .out_inexact(out_inexact)
    );

    task automatic send(input logic s, input logic [16:0] e, input logic [63:0] m,
                        input logic u, input logic [1:0] rm,
                        input logic [63:0] xr, input logic xiv, input logic xix,
                        input string tag);
        exp_t it;
        @(negedge clk);
        in_valid = 1'b1; in_sign = s; in_exp = e; in_sig = m;
        in_unsigned = u; in_rmode = rm;
        it.r = xr; it.iv = xiv; it.ix = xix; it.tag = tag;
        sb.push_back(it);
    endtask

    // monitor: pops one expected item per result
    always @(negedge clk) begin
        if (rst_n && out_valid) begin
            total++;
            if (sb.size() == 0) begin
                bad++;
                $display("FAIL R1 unexpected result int=%h", out_int);
            end else begin
                exp_t it;
                it = sb.pop_front();
                if (out_int !== it.r || out_invalid !== it.iv || out_inexact !== it.ix) begin
                    bad++;
                    $display("FAIL %s actual int=%h inv=%b inx=%b expected int=%h inv=%b inx=%b",
                             it.tag, out_int, out_invalid, out_inexact, it.r, it.iv, it.ix);
                end
            end
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        total++;
        if (out_valid !== 1'b0 || out_int !== '0 || out_invalid !== 1'b0 || out_inexact !== 1'b0) begin
            bad++;
            $display("FAIL R1 reset state actual v=%b int=%h expected v=0 int=0",
                     out_valid, out_int);
        end
        rst_n = 1'b1;

        // R8 basic values and zero
        send(0, 17'h0FFFF, ONE, 0, 2'b11, 64'd1, 0, 0, "R8 one");
        send(0, 17'h00000, 64'd0, 0, 2'b00, 64'd0, 0, 0, "R8 zero");
        send(0, 17'h1003F, 64'd1, 0, 2'b11, 64'd2, 0, 0, "R8 unnormal left shift");
        // R6 rounding of 2.5 / -2.5 / 3.5 / 0.5
        send(0, 17'h10000, 64'hA000_0000_0000_0000, 0, 2'b00, 64'd2, 0, 1, "R6 2.5 near-even");
        send(0, 17'h10000, 64'hA000_0000_0000_0000, 0, 2'b10, 64'd3, 0, 1, "R6 2.5 up");
        send(0, 17'h10000, 64'hA000_0000_0000_0000, 0, 2'b11, 64'd2, 0, 1, "R6 2.5 zero");
        send(1, 17'h10000, 64'hA000_0000_0000_0000, 0, 2'b00, 64'hFFFF_FFFF_FFFF_FFFE, 0, 1, "R6 -2.5 near-even");
        send(1, 17'h10000, 64'hA000_0000_0000_0000, 0, 2'b01, 64'hFFFF_FFFF_FFFF_FFFD, 0, 1, "R6 -2.5 down");
        send(1, 17'h10000, 64'hA000_0000_0000_0000, 0, 2'b10, 64'hFFFF_FFFF_FFFF_FFFE, 0, 1, "R6 -2.5 up");
        send(0, 17'h10000, 64'hE000_0000_0000_0000, 0, 2'b00, 64'd4, 0, 1, "R6 3.5 near-even");
        send(0, 17'h0FFFE, ONE, 0, 2'b00, 64'd0, 0, 1, "R7 0.5 tie to zero");
        send(0, 17'h0FFFE, ONE, 0, 2'b10, 64'd1, 0, 1, "R6 0.5 up");
        // R2 / R3 specials
        send(0, 17'h1FFFF, 64'hC000_0000_0000_0000, 0, 2'b00, IND, 1, 0, "R2 NaN signed");
        send(1, 17'h1FFFF, 64'hC000_0000_0000_0001, 1, 2'b11, IND, 1, 0, "R3 NaN unsigned");
        send(0, 17'h1FFFF, ONE, 1, 2'b01, IND, 1, 0, "R2 infinity");
        // R4 signed range
        send(1, 17'h1003E, ONE, 0, 2'b00, IND, 0, 0, "R4 minus 2^63 valid");
        send(0, 17'h1003E, ONE, 0, 2'b00, IND, 1, 0, "R4 plus 2^63 invalid");
        send(0, 17'h1003D, 64'hFFFF_FFFF_FFFF_FFFE, 0, 2'b00, 64'h7FFF_FFFF_FFFF_FFFF, 0, 0, "R4 max positive");
        send(0, 17'h1003D, 64'hFFFF_FFFF_FFFF_FFFF, 0, 2'b00, IND, 1, 0, "R6 round into overflow");
        send(0, 17'h1003D, 64'hFFFF_FFFF_FFFF_FFFF, 0, 2'b11, 64'h7FFF_FFFF_FFFF_FFFF, 0, 1, "R7 truncate below limit");
        send(0, 17'h1003E, 64'hFFFF_FFFF_FFFF_FFFF, 0, 2'b11, IND, 1, 0, "R4 2^64-1 signed");
        // R5 unsigned range
        send(0, 17'h1003E, ONE, 1, 2'b00, IND, 0, 0, "R5 2^63 unsigned valid");
        send(0, 17'h1003E, 64'hFFFF_FFFF_FFFF_FFFF, 1, 2'b00, 64'hFFFF_FFFF_FFFF_FFFF, 0, 0, "R5 2^64-1 unsigned");
        send(0, 17'h1003F, ONE, 1, 2'b11, IND, 1, 0, "R5 2^64 unsigned");
        send(1, 17'h0FFFD, ONE, 1, 2'b11, 64'd0, 0, 1, "R5 -0.25 toward zero");
        send(1, 17'h0FFFD, ONE, 1, 2'b01, IND, 1, 0, "R5 -0.25 down");
        send(1, 17'h0FFFF, ONE, 1, 2'b11, IND, 1, 0, "R5 -1 unsigned");

        @(negedge clk);
        in_valid = 1'b0;
        repeat (3) @(negedge clk);
        total++;
        if (out_valid !== 1'b0 || sb.size() != 0) begin
            bad++;
            $display("FAIL R1 idle actual v=%b pending=%0d expected v=0 pending=0",
                     out_valid, sb.size());
        end
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL R1 watchdog actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule